// File: doc/BRIEF.md
# Discharge Capacity Learning Unit

This block learns the usable capacity of a battery from its own discharges. It counts the units of charge drawn from the pack, starting at the moment a discharge is armed and running to the empty-voltage threshold. If the discharge meets every qualification condition, the count is copied into the learned full-capacity register on the first valid charge that follows.

A companion gauge supplies the unit pulses and the status conditions. Those are the discharge and self-discharge units, charge increments, the arm request, the empty-voltage flag, the cold-temperature flag and the "available capacity is zero" condition. The gauge also supplies the programmed full capacity, and it reads back the running count, the learned capacity and the qualification flag.

The learned capacity never falls by more than a quarter in one update. The counter saturates instead of wrapping, and it keeps counting real discharge after the available capacity has reached zero.

Top module: `cap_learn_top`

## Requirements
- R1: While `rst_n` is low, `dsc_count` is 0, `qual_flag` is 0 and `learned_cap` is loaded with `prog_cap`.
- R2: A `qual_set` pulse in a cycle makes `qual_flag` 1 in the next cycle and clears `dsc_count` and the self-discharge accumulator to 0. It takes priority over every other input in that cycle.
- R3: Each cycle, `dsc_count` grows by `dsc_pulse` plus (`selfdsc_pulse` AND NOT `avail_zero`), so it grows by 0, 1 or 2. Self-discharge is not counted once `avail_zero` is 1.
- R4: `dsc_count` saturates at 0xFFFF and never wraps.
- R5: The self-discharge accumulator counts the counted self-discharge units, saturating at 0xFFFF. When empty is reached, the discharge qualifies only if the accumulator is at most `prog_cap / 10` (integer division).
- R6: While armed, `empty_flag` with `temp_ok` = 1 and the self-discharge limit met keeps `qual_flag` at 1. The next `chg_pulse` then loads `learned_cap` from `dsc_count`, subject to R7, and clears `qual_flag`.
- R7: A transfer writes max(`dsc_count`, L - (L >> 2)), where L is the previous `learned_cap`.
- R8: While armed, `empty_flag` with `temp_ok` = 0, or with the self-discharge limit exceeded, clears `qual_flag`. No transfer follows.
- R9: A `chg_pulse` while armed and before empty clears `qual_flag` without a transfer. If `chg_pulse` and `empty_flag` arrive in the same cycle, the charge wins.
- R10: `learned_cap` changes only on a transfer or a reset. After a transfer, further charge pulses change nothing until `qual_set` arms again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dsc_pulse | input | 1 | One discharge unit |
| selfdsc_pulse | input | 1 | One self-discharge unit |
| chg_pulse | input | 1 | One charge increment (valid charge) |
| qual_set | input | 1 | Arm a new learning discharge |
| empty_flag | input | 1 | Empty-voltage threshold reached |
| temp_ok | input | 1 | Temperature at or above 0 degrees C |
| avail_zero | input | 1 | Available capacity is zero |
| prog_cap | input | 16 | Programmed full capacity |
| dsc_count | output | 16 | Running discharge count |
| learned_cap | output | 16 | Learned full capacity |
| qual_flag | output | 1 | Present discharge still valid for learning |

## Verification
Some properties are checked on every cycle: arming through `qual_set`, saturation of the counter, the rule that the counter never decreases between arms, the 75% floor on any update, the stability of the learned capacity outside a charge while qualified, and the loss of qualification on a charge. Other behaviour only the bench scenarios can show. This covers the exact increment amount for each pulse mix, the self-discharge limit at exactly `prog_cap / 10` and one unit above it, the cold-empty rejection, the early-charge rejection, the value actually transferred, and reloading from `prog_cap` at reset.

// File: rtl/cap_learn_pkg.sv
// Shared types and helpers for the discharge capacity learning unit.
// Assumes all capacity quantities share one unsigned width.
package cap_learn_pkg;

    // Learning sequence: idle, armed and waiting for empty, qualified and waiting for charge
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_READY = 2'd2
    } learn_state_t;

    // Saturating add of a small increment to a 16-bit value
    function automatic logic [15:0] sat_add16(input logic [15:0] base, input logic [1:0] inc);
        logic [16:0] sum;
        sum = {1'b0, base} + {15'd0, inc};
        return sum[16] ? 16'hFFFF : sum[15:0];
    endfunction

endpackage

// File: rtl/cap_dcount.sv
// Discharge counter and self-discharge accumulator.
// Both saturate at the maximum value and are cleared by the arm request.
// Self-discharge is counted only while available capacity is nonzero.
module cap_dcount #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         dsc_pulse,
    input  logic         selfdsc_pulse,
    input  logic         avail_zero,
    output logic [W-1:0] count,
    output logic [W-1:0] self_acc
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic       sd_eff;
    logic [1:0] inc;
    logic [W:0] cnt_sum;

    // Work out this cycle's increment
    always_comb begin
        sd_eff  = selfdsc_pulse & ~avail_zero;
        inc     = {1'b0, dsc_pulse} + {1'b0, sd_eff};
        cnt_sum = {1'b0, count} + {{(W-1){1'b0}}, inc};
    end

    // Main discharge counter with saturation
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (cnt_sum[W]) begin
            count <= MAXV;
        end else begin
            count <= cnt_sum[W-1:0];
        end
    end

    // Self-discharge accumulator with saturation
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            self_acc <= '0;
        end else if (sd_eff && self_acc != MAXV) begin
            self_acc <= self_acc + 1'b1;
        end
    end
endmodule

// File: rtl/cap_qual_fsm.sv
// Qualification sequencer: arms on request, checks conditions at empty,
// and issues a one-cycle transfer on the first charge after a good empty.
// Arming wins over everything; a charge wins over empty in the same cycle.
module cap_qual_fsm
    import cap_learn_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         qual_set,
    input  logic         chg_pulse,
    input  logic         empty_flag,
    input  logic         temp_ok,
    input  logic [W-1:0] self_acc,
    input  logic [W-1:0] prog_cap,
    output logic         qual_flag,
    output logic         xfer
);
    localparam logic [W-1:0] TEN = W'(10);

    learn_state_t state, state_nx;
    logic [W-1:0] sd_limit;
    logic         sd_ok;

    // Self-discharge limit of one tenth of programmed capacity
    always_comb begin
        sd_limit = prog_cap / TEN;
        sd_ok    = (self_acc <= sd_limit);
    end

    // Next-state and transfer decision
    always_comb begin
        state_nx = state;
        xfer     = 1'b0;
        if (qual_set) begin
            state_nx = ST_ARMED;
        end else begin
            unique case (state)
                ST_ARMED: begin
                    if (chg_pulse) begin
                        state_nx = ST_IDLE;
                    end else if (empty_flag) begin
                        state_nx = (temp_ok && sd_ok) ? ST_READY : ST_IDLE;
                    end
                end
                ST_READY: begin
                    if (chg_pulse) begin
                        state_nx = ST_IDLE;
                        xfer     = 1'b1;
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Qualification flag is high in any non-idle state
    assign qual_flag = (state != ST_IDLE);
endmodule

// File: rtl/cap_lmd_reg.sv
// Learned full-capacity register. Loads the programmed capacity at reset
// and, on transfer, takes the counter value clamped to 75% of its old value.
module cap_lmd_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         xfer,
    input  logic [W-1:0] count,
    input  logic [W-1:0] prog_cap,
    output logic [W-1:0] learned
);
    logic [W-1:0] floor_v;
    logic [W-1:0] next_v;

    // Lowest value one update may reach, then the clamped candidate
    always_comb begin
        floor_v = learned - (learned >> 2);
        next_v  = (count < floor_v) ? floor_v : count;
    end

    // Register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            learned <= prog_cap;
        end else if (xfer) begin
            learned <= next_v;
        end
    end
endmodule

// File: rtl/cap_learn_top.sv
// Top of the discharge capacity learning unit: counter, sequencer and
// learned-capacity register. All outputs come straight from registers.
module cap_learn_top #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dsc_pulse,
    input  logic         selfdsc_pulse,
    input  logic         chg_pulse,
    input  logic         qual_set,
    input  logic         empty_flag,
    input  logic         temp_ok,
    input  logic         avail_zero,
    input  logic [W-1:0] prog_cap,
    output logic [W-1:0] dsc_count,
    output logic [W-1:0] learned_cap,
    output logic         qual_flag
);
    logic [W-1:0] self_acc;
    logic         xfer;

    cap_dcount #(.W(W)) u_dcount (
        .clk           (clk),
        .rst_n         (rst_n),
        .clr           (qual_set),
        .dsc_pulse     (dsc_pulse),
        .selfdsc_pulse (selfdsc_pulse),
        .avail_zero    (avail_zero),
        .count         (dsc_count),
        .self_acc      (self_acc)
    );

    cap_qual_fsm #(.W(W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .qual_set   (qual_set),
        .chg_pulse  (chg_pulse),
        .empty_flag (empty_flag),
        .temp_ok    (temp_ok),
        .self_acc   (self_acc),
        .prog_cap   (prog_cap),
        .qual_flag  (qual_flag),
        .xfer       (xfer)
    );

    cap_lmd_reg #(.W(W)) u_lmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfer     (xfer),
        .count    (dsc_count),
        .prog_cap (prog_cap),
        .learned  (learned_cap)
    );
endmodule

// File: rtl/cap_learn_chk.sv
// Cycle-level properties of the learning unit, bound to the top module.
module cap_learn_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         qual_set,
    input logic         chg_pulse,
    input logic [W-1:0] dsc_count,
    input logic [W-1:0] learned_cap,
    input logic         qual_flag
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        qual_set |=> (qual_flag && dsc_count == '0)); // R2

    AST_COUNT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_set |=> dsc_count >= $past(dsc_count)); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_count == MAXV && !qual_set) |=> dsc_count == MAXV); // R4

    AST_LEARN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_flag && chg_pulse) |=> learned_cap >= ($past(learned_cap) - ($past(learned_cap) >> 2))); // R7

    AST_CHARGE_DEQUALIFIES: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_flag && chg_pulse && !qual_set) |=> !qual_flag); // R9

    AST_LEARN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(qual_flag && chg_pulse) |=> $stable(learned_cap)); // R10
endmodule

bind cap_learn_top cap_learn_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .qual_set    (qual_set),
    .chg_pulse   (chg_pulse),
    .dsc_count   (dsc_count),
    .learned_cap (learned_cap),
    .qual_flag   (qual_flag)
);

// File: tb/cap_learn_top_bench.sv
module cap_learn_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dsc_pulse = 1'b0, selfdsc_pulse = 1'b0, chg_pulse = 1'b0;
    logic        qual_set = 1'b0, empty_flag = 1'b0, temp_ok = 1'b1, avail_zero = 1'b0;
    logic [15:0] prog_cap = 16'd1000;
    logic [15:0] dsc_count, learned_cap;
    logic        qual_flag;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cap_learn_top u_cap_learn_top (
        .clk(clk), .rst_n(rst_n), .dsc_pulse(dsc_pulse), .selfdsc_pulse(selfdsc_pulse),
        .chg_pulse(chg_pulse), .qual_set(qual_set), .empty_flag(empty_flag),
        .temp_ok(temp_ok), .avail_zero(avail_zero), .prog_cap(prog_cap),
        .dsc_count(dsc_count), .learned_cap(learned_cap), .qual_flag(qual_flag)
    );

    // {qs, dsc, sd, az, exp_qual, exp_cnt[15:0]}
    localparam logic [20:0] VEC [0:8] = '{
        {4'b1000, 1'b1, 16'd0},
        {4'b0100, 1'b1, 16'd1},
        {4'b0010, 1'b1, 16'd2},
        {4'b0011, 1'b1, 16'd2},
        {4'b0110, 1'b1, 16'd4},
        {4'b0101, 1'b1, 16'd5},
        {4'b0000, 1'b1, 16'd5},
        {4'b1100, 1'b1, 16'd0},
        {4'b0110, 1'b1, 16'd2}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        dsc_pulse = 0; selfdsc_pulse = 0; chg_pulse = 0; qual_set = 0; empty_flag = 0;
    endtask

    // Hold the current inputs for n clock edges, then drop the pulses
    task automatic hold(input int n);
        repeat (n) @(negedge clk);
        idle_inputs();
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        hold(2);
        rst_n = 1;
    endtask

    task automatic arm();
        qual_set = 1; hold(1);
    endtask

    task automatic empty_hit(input logic warm);
        temp_ok = warm; empty_flag = 1; hold(1); temp_ok = 1;
    endtask

    task automatic charge();
        chg_pulse = 1; hold(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        check("R1 count", dsc_count, 16'd0);
        check("R1 qual", {15'd0, qual_flag}, 16'd0);
        check("R1 learned", learned_cap, 16'd1000);

        // Vector walk for R2/R3 increment rules
        for (int i = 0; i < 9; i++) begin
            {qual_set, dsc_pulse, selfdsc_pulse, avail_zero} = VEC[i][20:17];
            hold(1);
            avail_zero = 0;
            check($sformatf("R3 vec %0d count", i), dsc_count, VEC[i][15:0]);
            check($sformatf("R2 vec %0d qual", i), {15'd0, qual_flag}, {15'd0, VEC[i][16]});
        end

        // R4 saturation
        arm();
        dsc_pulse = 1; selfdsc_pulse = 1; hold(32770);
        check("R4 saturated", dsc_count, 16'hFFFF);
        dsc_pulse = 1; hold(1);
        check("R4 holds", dsc_count, 16'hFFFF);

        // R6 qualified transfer, count keeps going after empty with only real discharge
        do_reset();
        arm();
        dsc_pulse = 1; hold(900);
        selfdsc_pulse = 1; hold(50);
        empty_hit(1);
        check("R6 qual after good empty", {15'd0, qual_flag}, 16'd1);
        avail_zero = 1; selfdsc_pulse = 1; dsc_pulse = 1; hold(10); avail_zero = 0;
        check("R3 count after empty", dsc_count, 16'd960);
        charge();
        check("R6 learned", learned_cap, 16'd960);
        check("R6 qual cleared", {15'd0, qual_flag}, 16'd0);
        charge();
        check("R10 no second transfer", learned_cap, 16'd960);

        // R7 floor at 75%
        arm();
        dsc_pulse = 1; hold(100);
        empty_hit(1);
        charge();
        check("R7 floor", learned_cap, 16'd720);

        // R5 self-discharge one unit over limit
        arm();
        selfdsc_pulse = 1; hold(101);
        empty_hit(1);
        check("R5 over limit dequalifies", {15'd0, qual_flag}, 16'd0);
        charge();
        check("R5 no transfer", learned_cap, 16'd720);

        // R5 exactly at limit qualifies
        arm();
        selfdsc_pulse = 1; hold(100);
        dsc_pulse = 1; hold(700);
        empty_hit(1);
        charge();
        check("R5 at limit transfers", learned_cap, 16'd800);

        // R8 cold at empty
        arm();
        dsc_pulse = 1; hold(850);
        empty_hit(0);
        check("R8 cold dequalifies", {15'd0, qual_flag}, 16'd0);
        charge();
        check("R8 no transfer", learned_cap, 16'd800);

        // R9 charge before empty
        arm();
        dsc_pulse = 1; hold(700);
        charge();
        check("R9 early charge dequalifies", {15'd0, qual_flag}, 16'd0);
        empty_hit(1);
        charge();
        check("R9 no transfer", learned_cap, 16'd800);

        // R9 charge and empty together: charge wins
        arm();
        dsc_pulse = 1; hold(700);
        chg_pulse = 1; empty_flag = 1; hold(1);
        check("R9 same-cycle charge wins", {15'd0, qual_flag}, 16'd0);
        charge();
        check("R9 same-cycle no transfer", learned_cap, 16'd800);

        // R1 reset reloads programmed capacity
        prog_cap = 16'd2000;
        do_reset();
        check("R1 reload", learned_cap, 16'd2000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule